// File: doc/BRIEF.md
# Cache ECC Error Record Unit

This unit sits beside a shared cache and keeps a software-visible record of ECC events. The tag (directory) array and the data array each report corrected and uncorrected errors as single-cycle pulses, and each pulse carries the physical address that failed. That gives four error classes. For each class the unit keeps the most recent failing address and a saturating event count, and it drives a dedicated interrupt line. The interrupt is acknowledged by reading that class's count register.

A 32-bit register bus with read and write strobes and a 12-bit byte offset gives access to the records. The same bus exposes a constant geometry word, a constant register holding the largest enabled way index, and an error-injection control register. The injection register accepts only a restricted range of values. An accepted write produces a one-cycle injection pulse together with a target-array select and a bit index. The cache arrays and the injection datapath are outside the unit.

Top module: `ecc_err_regs`

## Requirements
- R1: After reset, all interrupts, counts, latched addresses, the injection pulse, the injection readback and `bus_rdata` are zero.
- R2: Offset 0x00 reads {log2 bytes per block [31:24], log2 sets per bank [23:16], way count [15:8], bank count [7:0]}. Offset 0x08 reads the largest enabled way index in bits 7:0, with zero above it. Both values come from parameters.
- R3: An event pulse on class c sets `irq[c]` from the next cycle. It latches `evt_addr[c]`, which replaces any earlier address. The address low word reads at record base + 0x0, and the high word, zero-extended, reads at base + 0x4.
- R4: Each event pulse increments the class count, which reads at base + 0x8. A bus read of that count register clears `irq[c]` from the next cycle and leaves the count unchanged.
- R5: Reading a class's address registers, or any other register, leaves that class's interrupt unchanged. A read of one class's count register leaves the other classes' interrupts unchanged.
- R6: When an event and a read of the same class's count register fall in one cycle, the count increments and `irq[c]` stays 1.
- R7: A count saturates at all ones of CNT_W bits and does not wrap.
- R8: Class indices and record bases are: 0 = tag corrected at 0x100, 1 = data corrected at 0x140, 2 = data uncorrected at 0x160, 3 = tag uncorrected at 0x120. The class index selects bit c of `evt_pulse`, `evt_addr` and `irq`.
- R9: A write to offset 0x40 is valid when the value is below 0xFF, or is at least 0x10000 and below 0x100FF. A valid write raises `inj_pulse` for exactly the next cycle. It sets `inj_target` to bit 16 and `inj_bit` to bits 7:0, and both hold until the next valid write. Offset 0x40 reads back {bit 16 = target, bits 7:0 = bit index}.
- R10: Any other value written to 0x40 is ignored: no pulse, and the outputs and the readback are unchanged.
- R11: Writes to any offset other than 0x40 change nothing. Reads of unmapped offsets (for example 0x04 and 0x10C) return zero.
- R12: `bus_rdata` takes the addressed value at the clock edge on which `bus_rd` is high. It then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | NCLASS (4) | One-cycle ECC event per class, indexed as in R8 |
| evt_addr | input | NCLASS x ADDR_W | Failing physical address per class |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | NCLASS (4) | Per-class interrupt lines |
| inj_pulse | output | 1 | One-cycle injection request |
| inj_target | output | 1 | Injection target array select |
| inj_bit | output | 8 | Bit index to corrupt |

## Verification
Two things can land on the same class in the same cycle: a new event pulse and the bus read of that class's count register. One sets the interrupt and the other clears it. A directed step issues both together and expects the count to go up by one with the interrupt still high. The random phase makes events frequent and count reads common, so the collision recurs across all four classes. Every cycle the bench compares the interrupt vector with a model in which an event always wins over the read-clear.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

   localparam int NCLASS = 4;

   // class index order is visible on evt_pulse / irq bit positions
   typedef enum logic [1:0] {
      CLS_TAG_FIX  = 2'd0,
      CLS_DAT_FIX  = 2'd1,
      CLS_DAT_FAIL = 2'd2,
      CLS_TAG_FAIL = 2'd3
   } err_class_e;

   localparam logic [11:0] OFF_GEOM = 12'h000;
   localparam logic [11:0] OFF_WAYS = 12'h008;
   localparam logic [11:0] OFF_INJ  = 12'h040;

   localparam logic [11:0] REC_LO  = 12'h0;
   localparam logic [11:0] REC_HI  = 12'h4;
   localparam logic [11:0] REC_CNT = 12'h8;

   function automatic logic [11:0] rec_base(input int idx);
      case (idx)
         0:       return 12'h100;
         1:       return 12'h140;
         2:       return 12'h160;
         default: return 12'h120;
      endcase
   endfunction

   function automatic logic inj_value_ok(input logic [31:0] w);
      return (w < 32'h0000_00FF) || ((w >= 32'h0001_0000) && (w < 32'h0001_00FF));
   endfunction

endpackage

// File: rtl/ecc_err_record.sv
module ecc_err_record #(
   parameter int ADDR_W = 64,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt,
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic              cnt_rd,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              irq
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
         irq    <= 1'b0;
      end else if (evt) begin
         // a new event always wins over a same-cycle acknowledge
         addr_q <= evt_addr;
         irq    <= 1'b1;
         if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end else if (cnt_rd) begin
         irq <= 1'b0;
      end
   end

endmodule

// File: rtl/ecc_inject_ctl.sv
module ecc_inject_ctl import ecc_err_pkg::*; (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_hit,
   input  logic [31:0] wdata,
   output logic        inj_pulse,
   output logic        inj_target,
   output logic [7:0]  inj_bit,
   output logic [31:0] readback
);

   logic accept;

   assign accept   = wr_hit && inj_value_ok(wdata);
   assign readback = {15'd0, inj_target, 8'd0, inj_bit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inj_pulse  <= 1'b0;
         inj_target <= 1'b0;
         inj_bit    <= '0;
      end else begin
         inj_pulse <= accept;
         if (accept) begin
            inj_target <= wdata[16];
            inj_bit    <= wdata[7:0];
         end
      end
   end

endmodule

// File: rtl/ecc_err_regs.sv
module ecc_err_regs import ecc_err_pkg::*; #(
   parameter int ADDR_W     = 64,
   parameter int CNT_W      = 32,
   parameter int BANKS      = 4,
   parameter int WAYS       = 16,
   parameter int SETS_LOG2  = 10,
   parameter int BLOCK_LOG2 = 6,
   parameter int WAY_MAX    = 15
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NCLASS-1:0]              evt_pulse,
   input  logic [NCLASS-1:0][ADDR_W-1:0]  evt_addr,
   input  logic                           bus_rd,
   input  logic                           bus_wr,
   input  logic [11:0]                    bus_addr,
   input  logic [31:0]                    bus_wdata,
   output logic [31:0]                    bus_rdata,
   output logic [NCLASS-1:0]              irq,
   output logic                           inj_pulse,
   output logic                           inj_target,
   output logic [7:0]                     inj_bit
);

   localparam logic [31:0] GEOM_WORD = {8'(BLOCK_LOG2), 8'(SETS_LOG2), 8'(WAYS), 8'(BANKS)};
   localparam logic [31:0] WAYS_WORD = {24'd0, 8'(WAY_MAX)};

   // elaboration-time parameter checks
   if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr_w
      $error("ecc_err_regs: ADDR_W must be 1..64");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("ecc_err_regs: CNT_W must be 1..32");
   end
   if (BANKS < 1 || BANKS > 255 || WAYS < 1 || WAYS > 255) begin : g_bad_geom
      $error("ecc_err_regs: BANKS and WAYS must be 1..255");
   end
   if (SETS_LOG2 < 0 || SETS_LOG2 > 255 || BLOCK_LOG2 < 0 || BLOCK_LOG2 > 255) begin : g_bad_log2
      $error("ecc_err_regs: log2 fields must fit in 8 bits");
   end
   if (WAY_MAX < 0 || WAY_MAX >= WAYS) begin : g_bad_way_max
      $error("ecc_err_regs: WAY_MAX must be below WAYS");
   end

   logic [ADDR_W-1:0] rec_addr [NCLASS];
   logic [CNT_W-1:0]  rec_cnt  [NCLASS];
   logic [31:0]       word_lo  [NCLASS];
   logic [31:0]       word_hi  [NCLASS];
   logic [31:0]       word_cnt [NCLASS];
   logic [NCLASS-1:0] cnt_rd;

   for (genvar c = 0; c < NCLASS; c++) begin : g_rec
      assign cnt_rd[c] = bus_rd && (bus_addr == rec_base(c) + REC_CNT);

      ecc_err_record #(
         .ADDR_W (ADDR_W),
         .CNT_W  (CNT_W)
      ) u_rec (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt      (evt_pulse[c]),
         .evt_addr (evt_addr[c]),
         .cnt_rd   (cnt_rd[c]),
         .addr_q   (rec_addr[c]),
         .cnt_q    (rec_cnt[c]),
         .irq      (irq[c])
      );

      assign word_cnt[c] = 32'(rec_cnt[c]);

      // address width picks how the two address words are formed
      if (ADDR_W > 32) begin : g_wide
         assign word_lo[c] = rec_addr[c][31:0];
         assign word_hi[c] = 32'(rec_addr[c][ADDR_W-1:32]);
      end else begin : g_narrow
         assign word_lo[c] = 32'(rec_addr[c]);
         assign word_hi[c] = '0;
      end
   end

   logic [31:0] inj_readback;

   ecc_inject_ctl u_inj (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit     (bus_wr && (bus_addr == OFF_INJ)),
      .wdata      (bus_wdata),
      .inj_pulse  (inj_pulse),
      .inj_target (inj_target),
      .inj_bit    (inj_bit),
      .readback   (inj_readback)
   );

   logic [31:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (bus_addr == OFF_GEOM) rd_mux = GEOM_WORD;
      if (bus_addr == OFF_WAYS) rd_mux = WAYS_WORD;
      if (bus_addr == OFF_INJ)  rd_mux = inj_readback;
      for (int c = 0; c < NCLASS; c++) begin
         if (bus_addr == rec_base(c) + REC_LO)  rd_mux = word_lo[c];
         if (bus_addr == rec_base(c) + REC_HI)  rd_mux = word_hi[c];
         if (bus_addr == rec_base(c) + REC_CNT) rd_mux = word_cnt[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         bus_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/ecc_err_regs_chk.sv
module ecc_err_regs_chk import ecc_err_pkg::*; (
   input logic              clk,
   input logic              rst_n,
   input logic [NCLASS-1:0] evt_pulse,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [11:0]       bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [NCLASS-1:0] irq,
   input logic              inj_pulse
);

   logic inj_wr;
   logic inj_shape_ok;

   assign inj_wr       = bus_wr && (bus_addr == 12'h040);
   // valid shape written differently from the design: no stray bits, low byte not all ones
   assign inj_shape_ok = (bus_wdata[31:17] == '0) && (bus_wdata[15:8] == '0) && (bus_wdata[7:0] != 8'hFF);

   for (genvar c = 0; c < NCLASS; c++) begin : g_cls
      logic cnt_hit;
      assign cnt_hit = bus_rd && (bus_addr == rec_base(c) + 12'h8);

      // R3: an event raises the line
      a_r3_evt_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
         evt_pulse[c] |=> irq[c]);

      // R3: no rise without an event
      a_r3_no_spurious_irq: assert property (@(posedge clk) disable iff (!rst_n)
         (!irq[c] && !evt_pulse[c]) |=> !irq[c]);

      // R4: count read acknowledges
      a_r4_cnt_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_hit && !evt_pulse[c]) |=> !irq[c]);

      // R5: only a count read of this class can drop the line
      a_r5_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (irq[c] && !cnt_hit) |=> irq[c]);

      // R6: event beats same-cycle acknowledge
      a_r6_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_hit && evt_pulse[c]) |=> irq[c]);
   end

   // R9: a pulse follows an injection-register write
   a_r9_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      inj_pulse |-> $past(inj_wr && inj_shape_ok));

   // R10: invalid injection value gives no pulse
   a_r10_invalid_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_wr && !inj_shape_ok) |=> !inj_pulse);

endmodule

bind ecc_err_regs ecc_err_regs_chk u_chk (.*);

// File: tb/tb_ecc_err_regs.sv
`timescale 1ns/1ps
module tb_ecc_err_regs;

   localparam int NC = 4;
   localparam int AW = 48;
   localparam int CW = 8;
   localparam int P_BANKS = 2, P_WAYS = 8, P_SETS = 9, P_BLK = 6, P_WMAX = 5;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [NC-1:0]           evt_pulse = '0;
   logic [NC-1:0][AW-1:0]   evt_addr = '0;
   logic                    bus_rd = 1'b0, bus_wr = 1'b0;
   logic [11:0]             bus_addr = '0;
   logic [31:0]             bus_wdata = '0;
   logic [31:0]             bus_rdata;
   logic [NC-1:0]           irq;
   logic                    inj_pulse, inj_target;
   logic [7:0]              inj_bit;

   ecc_err_regs #(.ADDR_W(AW), .CNT_W(CW), .BANKS(P_BANKS), .WAYS(P_WAYS),
                  .SETS_LOG2(P_SETS), .BLOCK_LOG2(P_BLK), .WAY_MAX(P_WMAX)) dut (.*);

   always #2 clk = ~clk;   // 250 MHz

   int checks = 0, errors = 0;

   // model
   logic [AW-1:0] m_addr [NC];
   logic [31:0]   m_cnt  [NC];
   logic [NC-1:0] m_irq = '0;
   logic          m_pulse = 1'b0, m_tgt = 1'b0;
   logic [7:0]    m_bit = '0;
   logic [31:0]   m_rdata = '0;

   function automatic logic [11:0] base_of(input int c);
      case (c) 0: return 12'h100; 1: return 12'h140; 2: return 12'h160; default: return 12'h120; endcase
   endfunction

   function automatic logic inj_ok(input logic [31:0] w);
      return (w < 32'hFF) || (w >= 32'h10000 && w < 32'h100FF);
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      logic [63:0] wide;
      if (a == 12'h000) return {8'(P_BLK), 8'(P_SETS), 8'(P_WAYS), 8'(P_BANKS)};
      if (a == 12'h008) return 32'(P_WMAX);
      if (a == 12'h040) return {15'd0, m_tgt, 8'd0, m_bit};
      for (int c = 0; c < NC; c++) begin
         wide = 64'(m_addr[c]);
         if (a == base_of(c))         return wide[31:0];
         if (a == base_of(c) + 12'h4) return wide[63:32];
         if (a == base_of(c) + 12'h8) return m_cnt[c];
      end
      return 32'd0;
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
      end
   endtask

   // one bus/event cycle; inputs driven after a falling edge, checked at the next one
   task automatic step(input logic [NC-1:0] ev, input logic rd, input logic wr,
                       input logic [11:0] a, input logic [31:0] wd, input string tag);
      logic [31:0] pre;
      logic [AW-1:0] na [NC];
      for (int c = 0; c < NC; c++) begin
         na[c] = AW'({$urandom, $urandom});
         evt_addr[c] = na[c];
      end
      evt_pulse = ev; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      pre = exp_read(a);
      @(negedge clk);
      if (rd) m_rdata = pre;
      for (int c = 0; c < NC; c++) begin
         if (ev[c]) begin
            m_addr[c] = na[c];
            m_irq[c]  = 1'b1;
            if (m_cnt[c] != 32'(2**CW - 1)) m_cnt[c] = m_cnt[c] + 1;
         end else if (rd && a == base_of(c) + 12'h8) begin
            m_irq[c] = 1'b0;
         end
      end
      m_pulse = wr && a == 12'h040 && inj_ok(wd);
      if (m_pulse) begin m_tgt = wd[16]; m_bit = wd[7:0]; end
      evt_pulse = '0; bus_rd = 0; bus_wr = 0;
      chk(irq == m_irq, {tag, " irq (R3 R4 R5 R6 R8)"}, 64'(irq), 64'(m_irq));
      chk(bus_rdata == m_rdata, {tag, " rdata (R12)"}, 64'(bus_rdata), 64'(m_rdata));
      chk(inj_pulse == m_pulse, {tag, " inj_pulse (R9 R10)"}, 64'(inj_pulse), 64'(m_pulse));
      chk({inj_target, inj_bit} == {m_tgt, m_bit}, {tag, " inj fields (R9 R10)"},
          64'({inj_target, inj_bit}), 64'({m_tgt, m_bit}));
   endtask

   task automatic rd_expect(input logic [11:0] a, input logic [31:0] v, input string tag);
      step('0, 1'b1, 1'b0, a, 32'd0, tag);
      chk(bus_rdata == v, tag, 64'(bus_rdata), 64'(v));
   endtask

   function automatic logic [11:0] pick_addr();
      int k = $urandom % 18;
      if (k < 12) return base_of(k / 3) + 12'(4 * (k % 3));
      case (k)
         12: return 12'h000; 13: return 12'h008; 14: return 12'h040;
         15: return 12'h004; 16: return 12'h10C; default: return 12'h168;
      endcase
   endfunction

   initial begin
      #(4 * 200000);
      errors++; checks++;
      $display("FAIL watchdog (all R) actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int c = 0; c < NC; c++) begin m_addr[c] = '0; m_cnt[c] = '0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(irq == '0 && inj_pulse == 0 && bus_rdata == 0, "R1 outputs at reset", 64'({irq, inj_pulse, bus_rdata}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      rd_expect(12'h108, 32'd0, "R1 count zero after reset");
      rd_expect(12'h164, 32'd0, "R1 address zero after reset");
      rd_expect(12'h040, 32'd0, "R1 inject readback zero");
      // R2: geometry and way register
      rd_expect(12'h000, {8'd6, 8'd9, 8'd8, 8'd2}, "R2 geometry word");
      rd_expect(12'h008, 32'd5, "R2 largest way index");
      // R3 R5 R8: each class, read its address words, irq stays
      for (int c = 0; c < NC; c++) begin
         step(4'(1 << c), 1'b0, 1'b0, 12'h0, 0, "R8 class event");
         chk(irq == 4'(1 << c), "R8 irq bit position", 64'(irq), 64'(1 << c));
         rd_expect(base_of(c), exp_read(base_of(c)), "R3 address low");
         rd_expect(base_of(c) + 12'h4, exp_read(base_of(c) + 12'h4), "R3 address high");
         chk(irq[c] == 1'b1, "R5 irq kept after address reads", 64'(irq[c]), 64'(1));
         rd_expect(base_of(c) + 12'h8, 32'd1, "R4 count one");
         chk(irq[c] == 1'b0, "R4 irq cleared by count read", 64'(irq[c]), 64'(0));
      end
      // R3: overwrite with newest address
      step(4'b0010, 0, 0, 0, 0, "R3 first event");
      step(4'b0010, 0, 0, 0, 0, "R3 second event");
      rd_expect(12'h140, exp_read(12'h140), "R3 newest address latched");
      // R5: another class's count read leaves irq[1]
      rd_expect(12'h108, 32'd1, "R5 other class count");
      chk(irq[1] == 1'b1, "R5 other class irq unaffected", 64'(irq[1]), 64'(1));
      // R6: event and count read in same cycle
      step(4'b0010, 1'b1, 1'b0, 12'h148, 0, "R6 collision");
      chk(irq[1] == 1'b1 && bus_rdata == 32'd3, "R6 irq held and pre-event count read",
          64'({irq[1], bus_rdata}), 64'({1'b1, 32'd3}));
      rd_expect(12'h148, 32'd4, "R6 count incremented");
      // R7: saturation
      for (int i = 0; i < 300; i++) step(4'b0100, 0, 0, 0, 0, "R7 burst");
      rd_expect(12'h168, 32'hFF, "R7 count saturated");
      // R9 R10: injection boundaries
      step('0, 0, 1, 12'h040, 32'h000000FE, "R9 low max valid");
      chk(inj_pulse && inj_bit == 8'hFE && !inj_target, "R9 pulse fields", 64'({inj_pulse, inj_target, inj_bit}), 64'({1'b1, 1'b0, 8'hFE}));
      step('0, 0, 0, 0, 0, "R9 pulse one cycle");
      chk(!inj_pulse, "R9 single-cycle pulse", 64'(inj_pulse), 64'(0));
      step('0, 0, 1, 12'h040, 32'h000000FF, "R10 0xFF rejected");
      step('0, 0, 1, 12'h040, 32'h00010000, "R9 high min valid");
      chk(inj_target && inj_bit == 8'h00, "R9 target select", 64'({inj_target, inj_bit}), 64'({1'b1, 8'h00}));
      step('0, 0, 1, 12'h040, 32'h000100FE, "R9 high max valid");
      step('0, 0, 1, 12'h040, 32'h000100FF, "R10 0x100FF rejected");
      step('0, 0, 1, 12'h040, 32'h0000FFFF, "R10 0xFFFF rejected");
      rd_expect(12'h040, 32'h000100FE, "R10 readback unchanged");
      // R11: read-only writes and unmapped reads
      step('0, 0, 1, 12'h000, 32'hFFFFFFFF, "R11 write geometry");
      step('0, 0, 1, 12'h148, 32'h0, "R11 write count");
      rd_expect(12'h000, {8'd6, 8'd9, 8'd8, 8'd2}, "R11 geometry unchanged");
      rd_expect(12'h148, 32'd4, "R11 count unchanged");
      rd_expect(12'h10C, 32'd0, "R11 unmapped reads zero");
      rd_expect(12'h004, 32'd0, "R11 unmapped 0x04 zero");
      // R12: hold
      step('0, 0, 0, 12'h000, 0, "R12 rdata hold");
      // random phase
      for (int i = 0; i < 4000; i++) begin
         logic [NC-1:0] ev;
         logic rd, wr;
         logic [31:0] wd;
         logic [11:0] a;
         for (int c = 0; c < NC; c++) ev[c] = ($urandom % 6) == 0;
         rd = ($urandom % 2) == 0;
         wr = !rd && ($urandom % 3) == 0;
         a  = wr ? ((($urandom % 4) == 0) ? pick_addr() : 12'h040) : pick_addr();
         case ($urandom % 3)
            0: wd = $urandom % 32'h100;
            1: wd = 32'h10000 + ($urandom % 32'h100);
            default: wd = $urandom;
         endcase
         step(ev, rd, wr, a, wd, "random");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule